// File: doc/BRIEF.md
# Multi-Function 8-bit Arithmetic Element

This block is a small word-level arithmetic unit meant to sit inside a DSP kernel datapath. A load strobe captures two 8-bit operands, an operation code and a carry-in into internal operand registers. On the following clock edge the selected operation runs through a shared datapath and its result lands in a 16-bit result register, with a one-cycle valid flag. Every operation takes exactly one evaluation cycle, and loads may be issued on consecutive cycles to keep the element busy.

The datapath is built around a single reduction structure. Two 8x4 unsigned partial-product units each multiply the A operand by one half of B. A three-input carry-save stage then reduces the partial products, an operand constant or the fed-back result. It uses full-adder cells where three inputs can be nonzero and half-adder cells above that. A final adder split into 4-, 8- and 4-bit segments, with carries chained from the low segment upward, produces the 16-bit sum. Addition, subtraction, increment, decrement, accumulation, multiply, multiply-accumulate and left shift are all produced by choosing what enters this one structure.

Top module: `arith_elem8`

## Requirements
- R1: While `rst_n` is low at a clock edge, the result register clears to 0 and `valid_o` clears to 0.
- R2: When `load_i` is high at edge k, the operands, `op_i` and `cin_i` are captured. The result of that operation is on `result_o` with `valid_o` high after edge k+1. `valid_o` is high only in cycles that follow such an evaluation. Loads on consecutive cycles give results on consecutive cycles.
- R3: Code 0 (add) gives A + B + cin, zero-extended to 16 bits.
- R4: Code 1 (subtract) gives A − B modulo 2^16, for example 3 − 5 = 0xFFFE. The carry-in input is ignored.
- R5: Code 3 (increment) gives A + 1 and code 4 (decrement) gives A − 1 modulo 2^16, so decrement of 0 gives 0xFFFF. B and the carry-in are ignored for both.
- R6: Code 5 (multiply) gives the unsigned 16-bit product A × B.
- R7: Code 2 (accumulate) gives previous result + A. Code 6 (multiply-accumulate) gives previous result + A × B. Both wrap modulo 2^16, and B is ignored for accumulate.
- R8: Code 7 (shift) gives A shifted left by B[2:0] places, zero-filled, in 16 bits. B[7:3] is ignored.
- R9: In any cycle that does not follow an evaluation, `result_o` keeps its previous value.
- R10: Carries propagate across the 4/8/4-bit segment boundaries within the single evaluation cycle, for example 0x0FDC + 0x24 = 0x1000. A sum at or above 2^16 wraps, for example 0xFFFF + 1 = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code, captured on load |
| a_i | input | 8 | A operand, captured on load |
| b_i | input | 8 | B operand, captured on load |
| load_i | input | 1 | Load strobe: capture inputs and evaluate next cycle |
| cin_i | input | 1 | Carry-in used by the add operation |
| result_o | output | 16 | Registered 16-bit result |
| valid_o | output | 1 | High for one cycle when a new result is presented |

## Verification
The timing assertions assume that `load_i` is low while reset is held. They also assume reset lasts at least two edges, so the result register is already cleared when checking starts. The stimulus changes every input only on falling edges and keeps the load strobe low throughout reset. The arithmetic assertions take the captured operand registers as the only source of operands, which holds because the operand inputs are read solely when the strobe is high. The stimulus mixes back-to-back loads, idle gaps and ignored operand bits, so that both the pipelined and the holding behaviour are exercised.

// File: rtl/ae8_pkg.sv
// Package for the multi-function arithmetic element.
// Holds the operation code type and default widths shared by the
// datapath modules and the bench. Codes are fixed: the bench relies on them.
package ae8_pkg;

    localparam int AE_OPW  = 8;
    localparam int AE_LO_W = 4;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_ACC = 3'd2,
        OP_INC = 3'd3,
        OP_DEC = 3'd4,
        OP_MUL = 3'd5,
        OP_MAC = 3'd6,
        OP_SHL = 3'd7
    } ae_op_e;

endpackage

// File: rtl/ae8_pp_mult.sv
// Unsigned AW x BW partial-product multiplier.
// Combinational shift-and-add over the BW multiplier bits.
// Assumes unsigned operands; the output is the full-width product.
module ae8_pp_mult #(
    parameter int AW = 8,
    parameter int BW = 4,
    localparam int PW = AW + BW
) (
    input  logic [AW-1:0] mcand,
    input  logic [BW-1:0] mplier,
    output logic [PW-1:0] prod
);

    // Sum one shifted copy of the multiplicand per set multiplier bit
    always_comb begin
        prod = '0;
        for (int j = 0; j < BW; j++) begin
            if (mplier[j]) begin
                prod = prod + (PW'(mcand) << j);
            end
        end
    end

endmodule

// File: rtl/ae8_csa.sv
// Three-input carry-save compressor.
// Bits below FA_W take three inputs (full-adder cells). Bits from FA_W
// upward take only in_y and in_z (half-adder cells), since in_x is FA_W
// bits wide. The carry vector is returned already weighted (bit 0 = 0).
// The carry out of the top bit is dropped, so sum+carry wraps modulo 2^W.
module ae8_csa #(
    parameter int W    = 16,
    parameter int FA_W = 12
) (
    input  logic [FA_W-1:0] in_x,
    input  logic [W-1:0]    in_y,
    input  logic [W-1:0]    in_z,
    output logic [W-1:0]    sum_o,
    output logic [W-1:0]    cry_o
);

    logic [W-2:0] cy;

    assign cry_o = {cy, 1'b0};

    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i < FA_W && i < W - 1) begin : g_fa
            // Full-adder cell: three-input bit reduction
            assign sum_o[i] = in_x[i] ^ in_y[i] ^ in_z[i];
            assign cy[i]    = (in_x[i] & in_y[i]) | (in_x[i] & in_z[i]) | (in_y[i] & in_z[i]);
        end else if (i < W - 1) begin : g_ha
            // Half-adder cell: two-input bit reduction
            assign sum_o[i] = in_y[i] ^ in_z[i];
            assign cy[i]    = in_y[i] & in_z[i];
        end else begin : g_top
            // Top bit: sum only, its carry leaves the word
            assign sum_o[i] = in_y[i] ^ in_z[i];
        end
    end

endmodule

// File: rtl/ae8_seg_add.sv
// One segment of the final carry-propagate adder.
// Adds two W-bit slices plus a carry-in and returns the segment carry-out
// for the next segment up. Purely combinational.
module ae8_seg_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] sa,
    input  logic [W-1:0] sb,
    input  logic         ci,
    output logic [W-1:0] so,
    output logic         co
);

    // Segment sum with carry out
    always_comb begin
        {co, so} = {1'b0, sa} + {1'b0, sb} + {{W{1'b0}}, ci};
    end

endmodule

// File: rtl/arith_elem8.sv
// Multi-function arithmetic element (top).
// A load strobe captures operands, code and carry-in. The next edge writes
// the evaluated result into three segment registers (4/8/4 bits by default)
// and raises valid for one cycle. All operations share one path: operand
// select, carry-save compressor, segmented final adder.
// Assumes load_i is low while rst_n is low.
module arith_elem8
    import ae8_pkg::*;
#(
    parameter int OPW  = AE_OPW,
    parameter int LO_W = AE_LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [OPW-1:0]    a_i,
    input  logic [OPW-1:0]    b_i,
    input  logic              load_i,
    input  logic              cin_i,
    output logic [2*OPW-1:0]  result_o,
    output logic              valid_o
);

    localparam int RESW  = 2 * OPW;
    localparam int HALF  = OPW / 2;
    localparam int PPW   = OPW + HALF;
    localparam int MID_W = RESW - 2 * LO_W;
    localparam int HI_LO = LO_W + MID_W;
    localparam int SHW   = $clog2(OPW);
    localparam logic [RESW-1:0] K_ONE  = RESW'(1);
    localparam logic [RESW-1:0] K_ZERO = '0;

    logic [OPW-1:0]   a_r, b_r;
    ae_op_e           op_r;
    logic             cin_r;
    logic             pend_r;
    logic             valid_r;
    logic [LO_W-1:0]  res_lo;
    logic [MID_W-1:0] res_mid;
    logic [LO_W-1:0]  res_hi;
    logic [RESW-1:0]  res_all;

    logic [PPW-1:0]   pp [2];
    logic [PPW-1:0]   x_sel;
    logic [RESW-1:0]  y_sel, z_sel;
    logic             c0;
    logic [RESW-1:0]  csa_s, csa_c;
    logic [LO_W-1:0]  sum_lo;
    logic [MID_W-1:0] sum_mid;
    logic [LO_W-1:0]  sum_hi;
    logic             co1, co2, co_hi;

    assign res_all  = {res_hi, res_mid, res_lo};
    assign result_o = res_all;
    assign valid_o  = valid_r;

    // Capture operands, code and carry-in on the load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r   <= '0;
            b_r   <= '0;
            op_r  <= OP_ADD;
            cin_r <= 1'b0;
        end else if (load_i) begin
            a_r   <= a_i;
            b_r   <= b_i;
            op_r  <= ae_op_e'(op_i);
            cin_r <= cin_i;
        end
    end

    // Track a pending evaluation and the one-cycle valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_r  <= 1'b0;
            valid_r <= 1'b0;
        end else begin
            pend_r  <= load_i;
            valid_r <= pend_r;
        end
    end

    // Two partial products, one per half of the B operand
    for (genvar h = 0; h < 2; h++) begin : g_pp
        ae8_pp_mult #(.AW(OPW), .BW(HALF)) u_pp (
            .mcand  (a_r),
            .mplier (b_r[h*HALF +: HALF]),
            .prod   (pp[h])
        );
    end

    // Choose the three compressor inputs and the low carry-in per operation
    always_comb begin
        x_sel = '0;
        y_sel = '0;
        z_sel = '0;
        c0    = 1'b0;
        case (op_r)
            OP_ADD: begin
                x_sel = PPW'(a_r);
                y_sel = RESW'(b_r);
                c0    = cin_r;
            end
            OP_SUB: begin
                x_sel = PPW'(a_r);
                y_sel = ~RESW'(b_r);
                c0    = 1'b1;
            end
            OP_ACC: begin
                x_sel = PPW'(a_r);
                z_sel = res_all;
            end
            OP_INC: begin
                x_sel = PPW'(a_r);
                y_sel = K_ONE;
            end
            OP_DEC: begin
                x_sel = PPW'(a_r);
                y_sel = ~K_ZERO;
            end
            OP_MUL: begin
                x_sel = pp[0];
                y_sel = RESW'(pp[1]) << HALF;
            end
            OP_MAC: begin
                x_sel = pp[0];
                y_sel = RESW'(pp[1]) << HALF;
                z_sel = res_all;
            end
            OP_SHL: begin
                y_sel = RESW'(a_r) << b_r[SHW-1:0];
            end
            default: begin
                x_sel = '0;
            end
        endcase
    end

    ae8_csa #(.W(RESW), .FA_W(PPW)) u_csa (
        .in_x  (x_sel),
        .in_y  (y_sel),
        .in_z  (z_sel),
        .sum_o (csa_s),
        .cry_o (csa_c)
    );

    ae8_seg_add #(.W(LO_W)) u_seg_lo (
        .sa (csa_s[LO_W-1:0]),
        .sb (csa_c[LO_W-1:0]),
        .ci (c0),
        .so (sum_lo),
        .co (co1)
    );

    ae8_seg_add #(.W(MID_W)) u_seg_mid (
        .sa (csa_s[HI_LO-1:LO_W]),
        .sb (csa_c[HI_LO-1:LO_W]),
        .ci (co1),
        .so (sum_mid),
        .co (co2)
    );

    ae8_seg_add #(.W(LO_W)) u_seg_hi (
        .sa (csa_s[RESW-1:HI_LO]),
        .sb (csa_c[RESW-1:HI_LO]),
        .ci (co2),
        .so (sum_hi),
        .co (co_hi)
    );

    // Write the segment registers after a pending evaluation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo  <= '0;
            res_mid <= '0;
            res_hi  <= '0;
        end else if (pend_r) begin
            res_lo  <= sum_lo;
            res_mid <= sum_mid;
            res_hi  <= sum_hi;
        end
    end

    // R2
    valid_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ##1 valid_o);

    // R2
    valid_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(load_i, 2));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o));

    // R3
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(op_r) == OP_ADD) |->
        result_o == RESW'($past(a_r)) + RESW'($past(b_r)) + RESW'($past(cin_r)));

    // R6
    mul_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(op_r) == OP_MUL) |->
        result_o == RESW'($past(a_r)) * RESW'($past(b_r)));

    // R10
    acc_wrap_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(op_r) == OP_ACC) |->
        $past(co_hi) == ((17'($past(res_all)) + 17'($past(a_r))) > 17'h0FFFF));

endmodule

// File: tb/arith_elem8_bench.sv
`timescale 1ns/1ps
module arith_elem8_bench;
    import ae8_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0;
    logic [7:0]  a = '0, b = '0;
    logic        load = 1'b0, cin = 1'b0;
    logic [15:0] result;
    logic        valid;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // Behavioural reference state
    bit        m_pend, m_valid;
    int        m_res;
    int        m_a, m_b, m_op, m_cin;

    always #2 clk = ~clk;

    arith_elem8 u_arith_elem8 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .load_i(load), .cin_i(cin), .result_o(result), .valid_o(valid)
    );

    function automatic int ref_eval(int o, int x, int y, int ci, int acc);
        int r;
        case (o)
            0: r = x + y + ci;
            1: r = x - y;
            2: r = acc + x;
            3: r = x + 1;
            4: r = x - 1;
            5: r = x * y;
            6: r = acc + x * y;
            default: r = x * (2 ** (y % 8));
        endcase
        return r & 16'hFFFF;
    endfunction

    // Reference model: advances on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_valid = 0; m_res = 0;
        end else begin
            if (m_pend) m_res = ref_eval(m_op, m_a, m_b, m_cin, m_res);
            m_valid = m_pend;
            m_pend  = load;
            if (load) begin
                m_a = a; m_b = b; m_op = op; m_cin = cin;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R9 model result", result, m_res);
            chk("R2 model valid", valid, m_valid);
        end
    end

    task automatic run_op(int o, int x, int y, int ci, int exp, string tag);
        @(negedge clk);
        op = 3'(o); a = 8'(x); b = 8'(y); cin = ci[0]; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        chk(tag, result, exp);
        chk({tag, " valid"}, valid, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 result", result, 0);
        chk("R1 valid", valid, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        run_op(0, 200, 100, 1, 16'h012D, "R3 add");
        run_op(0, 8'hFF, 8'hFF, 1, 16'h01FF, "R3 add max");
        run_op(1, 3, 5, 1, 16'hFFFE, "R4 sub negative");
        run_op(1, 200, 55, 0, 145, "R4 sub");
        run_op(3, 8'hFF, 8'hAA, 1, 16'h0100, "R5 inc");
        run_op(4, 0, 8'h55, 1, 16'hFFFF, "R5 dec zero");
        run_op(4, 8'h80, 8'h01, 0, 16'h007F, "R5 dec");
        run_op(5, 8'hFF, 8'hFF, 0, 16'hFE01, "R6 mul max");
        run_op(5, 8'h12, 8'h34, 0, 16'h03A8, "R6 mul");
        run_op(5, 8'h0F, 8'hF0, 1, 16'h0E10, "R6 mul halves");
        run_op(5, 200, 200, 0, 16'h9C40, "R6 mul big");
        run_op(2, 8'h10, 8'hEE, 1, 16'h9C50, "R7 acc");
        run_op(6, 8'hFF, 8'hFF, 0, 16'h9A51, "R7 mac wrap");
        run_op(7, 8'hFF, 8'hFF, 0, 16'h7F80, "R8 shift 7");
        run_op(7, 8'h81, 8'h0B, 0, 16'h0408, "R8 shift upper ignored");
        run_op(0, 8'h0F, 8'h01, 0, 16'h0010, "R10 low carry");
        run_op(5, 8'h91, 8'h1C, 0, 16'h0FDC, "R10 setup");
        run_op(2, 8'h24, 0, 0, 16'h1000, "R10 chain carry");
        run_op(5, 8'hFF, 8'hFF, 0, 16'hFE01, "R10 setup wrap");
        run_op(2, 8'hFF, 0, 0, 16'hFF00, "R10 acc");
        run_op(2, 8'hFF, 0, 0, 16'hFFFF, "R10 acc top");
        run_op(2, 8'h01, 0, 0, 16'h0000, "R10 wrap");

        // R9: idle cycles with changing inputs hold the result
        run_op(0, 7, 9, 0, 16, "R9 setup");
        a = 8'hAB; b = 8'hCD; op = 3'd5;
        repeat (3) @(negedge clk);
        chk("R9 hold result", result, 16);
        chk("R9 hold valid", valid, 0);

        // R2: back-to-back loads
        @(negedge clk);
        op = 3'd0; a = 1; b = 2; cin = 0; load = 1;
        @(negedge clk);
        op = 3'd3; a = 7; b = 0;
        @(negedge clk);
        load = 0;
        chk("R2 first result", result, 3);
        chk("R2 first valid", valid, 1);
        @(negedge clk);
        chk("R2 second result", result, 8);
        chk("R2 second valid", valid, 1);
        @(negedge clk);
        chk("R2 valid drops", valid, 0);

        // Mixed stimulus checked by the per-clock model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            op = 3'($urandom_range(0, 7));
            a = 8'($urandom); b = 8'($urandom); cin = 1'($urandom);
            load = ($urandom_range(0, 3) != 0);
        end
        @(negedge clk);
        load = 0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule